// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Selectable Rounding

This block multiplies two complex fixed-point operands, `a` and `b`, and returns their product at a reduced width. It is intended for the twiddle-factor stages of a streaming FFT. Each operand has signed real and imaginary words of `IN_W` bits. A single valid flag marks the cycles that carry operands. The block first forms the full-precision product. It then discards `SHIFT` low bits using one of six rounding modes, and clamps the result to `OUT_W` signed bits. An output valid flag is aligned with the result.

The product arithmetic is chosen at compile time. One structure uses three real multipliers with pre- and post-adders. The other uses four real multipliers with one subtractor and one adder. The two structures give the same bits and have the same latency, so either one can replace the other without any change to the logic around the block. The rounding mode is also a compile-time parameter, and floor is the default.

The reset input is asynchronous and active low. Inside the block it is released synchronously, two clock edges after the pin goes high.

Top module: `cmul_top`

## Requirements
- R1: For every accepted operand pair, the output is round(F / 2^SHIFT), where F = (a_re·b_re − a_im·b_im) for `p_re` and F = (a_re·b_im + a_im·b_re) for `p_im`. The defaults are IN_W = OUT_W = 16 and SHIFT = 15.
- R2: `out_vld` equals `in_vld` delayed by exactly 4 clock cycles. The result belonging to an accepted pair appears in the same cycle that its `out_vld` is high.
- R3: A rounded result greater than 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1. A rounded result less than −2^(OUT_W−1) is output as −2^(OUT_W−1). Results are never wrapped.
- R4: Mode floor (code 0, the default) rounds toward minus infinity. In every mode, a product whose discarded bits are all zero passes through unchanged.
- R5: Mode ceiling (code 1) rounds toward plus infinity.
- R6: Mode toward-zero (code 2) drops the discarded bits of positive values and rounds negative values up.
- R7: Mode nearest (code 3) rounds to the closest value, and resolves an exact half toward plus infinity.
- R8: Mode round (code 4) rounds to the closest value, and resolves an exact half away from zero.
- R9: Mode convergent (code 5) rounds to the closest value, and resolves an exact half toward the even result.
- R10: The three-multiplier structure (ARCH code 0) and the four-multiplier structure (ARCH code 1) produce bit-identical `p_re`, `p_im` and `out_vld` for the same input sequence.
- R11: Operands offered while `in_vld` is low have no effect. During cycles where `out_vld` is low, `p_re` and `p_im` keep the last valid result.
- R12: While in reset, `out_vld`, `p_re` and `p_im` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands valid this cycle |
| a_re | input | IN_W | Real part of operand a (signed) |
| a_im | input | IN_W | Imaginary part of operand a (signed) |
| b_re | input | IN_W | Real part of operand b (signed) |
| b_im | input | IN_W | Imaginary part of operand b (signed) |
| out_vld | output | 1 | Product valid this cycle |
| p_re | output | OUT_W | Real part of the rounded product (signed) |
| p_im | output | OUT_W | Imaginary part of the rounded product (signed) |

## Verification
The bench builds twelve copies of the block. These cover all six rounding modes with each of the two arithmetic structures, using 16-bit operands, a 16-bit result and 15 discarded bits. All twelve copies receive the same stimulus.

Because all copies see the same operands, the bench can directly compare the two structures in each mode bit for bit. It can also hit exact-half ties with both even and odd quotients, and place them on either side of zero. Most-negative operands drive both result parts into saturation at both limits. Idle cycles carry garbage operands, which shows whether the held output ever changes.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Rounding applied when discarding low product bits; codes are fixed.
  typedef enum logic [2:0] {
    RND_FLOOR      = 3'd0,
    RND_CEIL       = 3'd1,
    RND_ZERO       = 3'd2,
    RND_NEAREST    = 3'd3,
    RND_ROUND      = 3'd4,
    RND_CONVERGENT = 3'd5
  } rnd_mode_e;

  // Real-multiplier structure of the complex product.
  typedef enum logic {
    ARCH_3MUL = 1'b0,
    ARCH_4MUL = 1'b1
  } mul_arch_e;

endpackage

// File: rtl/cmul_prod.sv
// Full-precision complex product: two register stages (products, sums).
module cmul_prod #(
  parameter int                  IN_W   = 16,
  parameter cmul_pkg::mul_arch_e ARCH   = cmul_pkg::ARCH_3MUL,
  localparam int                 FULL_W = 2*IN_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic signed [IN_W-1:0]   a_re,
  input  logic signed [IN_W-1:0]   a_im,
  input  logic signed [IN_W-1:0]   b_re,
  input  logic signed [IN_W-1:0]   b_im,
  output logic                     vld_o,
  output logic signed [FULL_W-1:0] re_o,
  output logic signed [FULL_W-1:0] im_o
);

  logic                     v2_d, v2_q, v3_d, v3_q;
  logic signed [FULL_W-1:0] re_d, im_d, re_q, im_q;

  always_comb begin
    v2_d = vld_i;
    v3_d = v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  if (ARCH == cmul_pkg::ARCH_3MUL) begin : g_three
    localparam int SW = IN_W + 1;
    localparam int PW = 2*IN_W + 1;

    logic signed [SW-1:0] s_ab, d_dc, s_cd;
    logic signed [PW-1:0] k1_d, k2_d, k3_d, k1_q, k2_q, k3_q;

    // pre-adders and the three multipliers
    always_comb begin
      s_ab = SW'(a_re) + SW'(a_im);
      d_dc = SW'(b_im) - SW'(b_re);
      s_cd = SW'(b_re) + SW'(b_im);
      k1_d = PW'(b_re) * PW'(s_ab);
      k2_d = PW'(a_re) * PW'(d_dc);
      k3_d = PW'(a_im) * PW'(s_cd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        k1_q <= '0;
        k2_q <= '0;
        k3_q <= '0;
      end else if (vld_i) begin
        k1_q <= k1_d;
        k2_q <= k2_d;
        k3_q <= k3_d;
      end
    end

    // post-adders
    always_comb begin
      re_d = FULL_W'(k1_q) - FULL_W'(k3_q);
      im_d = FULL_W'(k1_q) + FULL_W'(k2_q);
    end

    // Cross-check of the three-product form against the textbook form.
    logic signed [FULL_W-1:0] ref_re, ref_im;
    always_comb begin
      ref_re = FULL_W'(a_re) * FULL_W'(b_re) - FULL_W'(a_im) * FULL_W'(b_im);
      ref_im = FULL_W'(a_re) * FULL_W'(b_im) + FULL_W'(a_im) * FULL_W'(b_re);
    end

    AST_ARCH_EQUIV: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (re_o == $past(ref_re, 2)) && (im_o == $past(ref_im, 2))); // R10

  end else begin : g_four
    localparam int PW = 2*IN_W;

    logic signed [PW-1:0] rr_d, ii_d, ri_d, ir_d, rr_q, ii_q, ri_q, ir_q;

    always_comb begin
      rr_d = PW'(a_re) * PW'(b_re);
      ii_d = PW'(a_im) * PW'(b_im);
      ri_d = PW'(a_re) * PW'(b_im);
      ir_d = PW'(a_im) * PW'(b_re);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rr_q <= '0;
        ii_q <= '0;
        ri_q <= '0;
        ir_q <= '0;
      end else if (vld_i) begin
        rr_q <= rr_d;
        ii_q <= ii_d;
        ri_q <= ri_d;
        ir_q <= ir_d;
      end
    end

    always_comb begin
      re_d = FULL_W'(rr_q) - FULL_W'(ii_q);
      im_d = FULL_W'(ri_q) + FULL_W'(ir_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= '0;
      im_q <= '0;
    end else if (v2_q) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  assign vld_o = v3_q;
  assign re_o  = re_q;
  assign im_o  = im_q;

endmodule

// File: rtl/cmul_round_sat.sv
// Drops SHIFT low bits with the chosen rounding, clamps to OW, registers.
module cmul_round_sat #(
  parameter int                  IW    = 34,
  parameter int                  SHIFT = 15,
  parameter int                  OW    = 16,
  parameter cmul_pkg::rnd_mode_e RMODE = cmul_pkg::RND_FLOOR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [IW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);

  localparam int QW = IW - SHIFT;
  localparam int RW = QW + 1;
  localparam logic [SHIFT-1:0] HALF = SHIFT'(1) << (SHIFT - 1);

  if (SHIFT < 1 || QW < 2) begin : g_bad_cfg
    $error("cmul_round_sat: SHIFT must be at least 1 and below IW-1");
  end

  logic signed [QW-1:0]  q;
  logic [SHIFT-1:0]      frac;
  logic                  neg, nz, gt_half, eq_half, inc;
  logic signed [RW-1:0]  r_d;
  logic signed [OW-1:0]  y_d, y_q;

  always_comb begin
    q       = x_i[IW-1:SHIFT];
    frac    = x_i[SHIFT-1:0];
    neg     = x_i[IW-1];
    nz      = |frac;
    gt_half = frac > HALF;
    eq_half = frac == HALF;
    unique case (RMODE)
      cmul_pkg::RND_CEIL:       inc = nz;
      cmul_pkg::RND_ZERO:       inc = neg & nz;
      cmul_pkg::RND_NEAREST:    inc = gt_half | eq_half;
      cmul_pkg::RND_ROUND:      inc = neg ? gt_half : (gt_half | eq_half);
      cmul_pkg::RND_CONVERGENT: inc = gt_half | (eq_half & q[0]);
      default:                  inc = 1'b0;
    endcase
    r_d = RW'(q) + {{(RW-1){1'b0}}, inc};
  end

  if (RW > OW) begin : g_clamp
    localparam logic signed [RW-1:0] MAXV = {{(RW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [RW-1:0] MINV = {{(RW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    always_comb begin
      if (r_d > MAXV)      y_d = MAXV[OW-1:0];
      else if (r_d < MINV) y_d = MINV[OW-1:0];
      else                 y_d = r_d[OW-1:0];
    end

    AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (r_d > MAXV)) |=> (y_q == MAXV[OW-1:0])); // R3
    AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (r_d < MINV)) |=> (y_q == MINV[OW-1:0])); // R3
  end else begin : g_extend
    always_comb y_d = OW'(r_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_d;
  end

  assign y_o = y_q;

  AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (frac == '0)) |-> (r_d == RW'(q))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_q)); // R11

endmodule

// File: rtl/cmul_top.sv
// Pipelined complex multiplier: operand stage, product (2 stages), rounding.
module cmul_top #(
  parameter int                  IN_W  = 16,
  parameter int                  OUT_W = 16,
  parameter int                  SHIFT = IN_W - 1,
  parameter cmul_pkg::mul_arch_e ARCH  = cmul_pkg::ARCH_3MUL,
  parameter cmul_pkg::rnd_mode_e RMODE = cmul_pkg::RND_FLOOR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  a_re,
  input  logic signed [IN_W-1:0]  a_im,
  input  logic signed [IN_W-1:0]  b_re,
  input  logic signed [IN_W-1:0]  b_im,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] p_re,
  output logic signed [OUT_W-1:0] p_im
);

  localparam int FULL_W = 2*IN_W + 2;
  localparam int LAT    = 4;
  localparam int CW     = $clog2(LAT + 1);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  // stage 1: operand capture
  logic                   v1_d, v1_q;
  logic signed [IN_W-1:0] ar_q, ai_q, br_q, bi_q;

  always_comb v1_d = in_vld;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      v1_q <= 1'b0;
      ar_q <= '0;
      ai_q <= '0;
      br_q <= '0;
      bi_q <= '0;
    end else begin
      v1_q <= v1_d;
      if (in_vld) begin
        ar_q <= a_re;
        ai_q <= a_im;
        br_q <= b_re;
        bi_q <= b_im;
      end
    end
  end

  // stages 2-3: full-precision product
  logic                     v3;
  logic signed [FULL_W-1:0] re_full, im_full;

  cmul_prod #(
    .IN_W (IN_W),
    .ARCH (ARCH)
  ) u_prod (
    .clk   (clk),
    .rst_n (srst_n),
    .vld_i (v1_q),
    .a_re  (ar_q),
    .a_im  (ai_q),
    .b_re  (br_q),
    .b_im  (bi_q),
    .vld_o (v3),
    .re_o  (re_full),
    .im_o  (im_full)
  );

  // stage 4: rounding and clamping, one lane per component
  cmul_round_sat #(
    .IW    (FULL_W),
    .SHIFT (SHIFT),
    .OW    (OUT_W),
    .RMODE (RMODE)
  ) u_rnd_re (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (v3),
    .x_i   (re_full),
    .y_o   (p_re)
  );

  cmul_round_sat #(
    .IW    (FULL_W),
    .SHIFT (SHIFT),
    .OW    (OUT_W),
    .RMODE (RMODE)
  ) u_rnd_im (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (v3),
    .x_i   (im_full),
    .y_o   (p_im)
  );

  logic v4_d, v4_q;
  always_comb v4_d = v3;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) v4_q <= 1'b0;
    else         v4_q <= v4_d;
  end

  assign out_vld = v4_q;

  // cycles since reset release, saturating at LAT (for the latency check)
  logic [CW-1:0] cyc_d, cyc_q;
  always_comb cyc_d = (cyc_q == CW'(LAT)) ? cyc_q : cyc_q + CW'(1);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cyc_q <= '0;
    else         cyc_q <= cyc_d;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_q == CW'(LAT)) |-> (out_vld == $past(in_vld, 4))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!out_vld && (p_re == '0) && (p_im == '0))); // R12

endmodule

// File: tb/tb_cmul_top.sv
`timescale 1ns/1ps
module tb_cmul_top;
  import cmul_pkg::*;

  localparam int W  = 16;
  localparam int NI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                in_vld;
  logic signed [W-1:0] a_re, a_im, b_re, b_im;
  logic                ov [NI];
  logic signed [W-1:0] pr [NI];
  logic signed [W-1:0] pi [NI];

  // index = mode*2 + arch
  for (genvar m = 0; m < 6; m++) begin : g_m
    for (genvar k = 0; k < 2; k++) begin : g_a
      cmul_top #(
        .IN_W  (W),
        .OUT_W (W),
        .SHIFT (W-1),
        .ARCH  (mul_arch_e'(k)),
        .RMODE (rnd_mode_e'(m))
      ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .a_re    (a_re),
        .a_im    (a_im),
        .b_re    (b_re),
        .b_im    (b_im),
        .out_vld (ov[m*2+k]),
        .p_re    (pr[m*2+k]),
        .p_im    (pi[m*2+k])
      );
    end
  end

  int     n_run  = 0;
  int     n_fail = 0;
  bit     done   = 1'b0;
  string  mtag [6] = '{"R4", "R5", "R6", "R7", "R8", "R9"};

  bit     hv  [4];
  longint hre [4];
  longint him [4];
  longint last_re [NI];
  longint last_im [NI];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // rounding of a full product by 2^15, codes as in the requirements
  function automatic longint rnd(input longint x, input int mode);
    longint q, f;
    q = x >>> 15;
    f = x & 64'h7FFF;
    case (mode)
      1:       return q + ((f != 0) ? 1 : 0);
      2:       return q + ((x < 0 && f != 0) ? 1 : 0);
      3:       return q + ((f >= 16384) ? 1 : 0);
      4:       return q + (((x >= 0) ? (f >= 16384) : (f > 16384)) ? 1 : 0);
      5:       return q + (((f > 16384) || (f == 16384 && q[0])) ? 1 : 0);
      default: return q;
    endcase
  endfunction

  function automatic longint clampw(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check_lane(input int i, input longint full, input longint act,
                            input bit is_re);
    longint r, e;
    string  tag;
    r = rnd(full, i / 2);
    e = clampw(r);
    tag = (r != e) ? $sformatf("R3 sat lane%0d", i) :
                     $sformatf("R1/%s lane%0d", mtag[i/2], i);
    chk(act == e, tag, act, e);
    if (is_re) last_re[i] = e;
    else       last_im[i] = e;
  endtask

  task automatic check_outputs();
    for (int i = 0; i < NI; i++) begin
      chk(ov[i] == hv[3], $sformatf("R2 valid lane%0d", i), longint'(ov[i]), longint'(hv[3]));
      if (hv[3]) begin
        check_lane(i, hre[3], longint'(pr[i]), 1'b1);
        check_lane(i, him[3], longint'(pi[i]), 1'b0);
      end else begin
        chk(pr[i] == last_re[i], $sformatf("R11 hold re lane%0d", i), longint'(pr[i]), last_re[i]);
        chk(pi[i] == last_im[i], $sformatf("R11 hold im lane%0d", i), longint'(pi[i]), last_im[i]);
      end
      if (i % 2 == 1) begin
        chk(pr[i] == pr[i-1], $sformatf("R10 re lane%0d", i), longint'(pr[i]), longint'(pr[i-1]));
        chk(pi[i] == pi[i-1], $sformatf("R10 im lane%0d", i), longint'(pi[i]), longint'(pi[i-1]));
      end
    end
  endtask

  task automatic step(input bit v, input longint ar, input longint ai,
                      input longint br, input longint bi);
    @(negedge clk);
    check_outputs();
    for (int j = 3; j > 0; j--) begin
      hv[j]  = hv[j-1];
      hre[j] = hre[j-1];
      him[j] = him[j-1];
    end
    hv[0]  = v;
    hre[0] = ar*br - ai*bi;
    him[0] = ar*bi + ai*br;
    in_vld = v;
    a_re = W'(ar);
    a_im = W'(ai);
    b_re = W'(br);
    b_im = W'(bi);
  endtask

  function automatic longint rnd16();
    logic signed [W-1:0] t;
    t = W'($urandom);
    return longint'(t);
  endfunction

  function automatic longint tie16();
    longint base;
    base = ($urandom % 2 == 0) ? 16384 : -16384;
    return base + longint'($urandom % 3) - 1;
  endfunction

  initial begin
    in_vld = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    for (int j = 0; j < 4; j++) begin hv[j] = 1'b0; hre[j] = 0; him[j] = 0; end
    for (int i = 0; i < NI; i++) begin last_re[i] = 0; last_im[i] = 0; end
    void'($urandom(32'd24681357));

    // R12: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk(ov[i] == 1'b0, "R12 out_vld in reset", longint'(ov[i]), 0);
      chk(pr[i] == '0,   "R12 p_re in reset",    longint'(pr[i]), 0);
      chk(pi[i] == '0,   "R12 p_im in reset",    longint'(pi[i]), 0);
    end
    rst_n = 1'b1;
    repeat (6) step(1'b0, 0, 0, 0, 0);

    // directed ties (R7 R8 R9), tiny values (R5 R6), saturation (R3)
    step(1'b1,  1, 0, 16384, 0);
    step(1'b1, -1, 0, 16384, 0);
    step(1'b1,  3, 0, 16384, 0);
    step(1'b1, -3, 0, 16384, 0);
    step(1'b0, 12345, -222, 777, 999);   // R11: ignored operands
    step(1'b1,  1, 0, 16385, 0);
    step(1'b1,  1, 0, 16383, 0);
    step(1'b1,  1, 0, 1, 0);
    step(1'b1, -1, 0, 1, 0);
    step(1'b1,  0, 5, 0, -32768);
    step(1'b0, -32768, -32768, 32767, 32767);
    step(1'b0, 1, 1, 1, 1);
    step(1'b1, -32768, -32768, -32768, -32768);
    step(1'b1, -32768, 32767, -32768, -32768);
    step(1'b1, 32767, -32768, 32767, 32767);
    step(1'b1, -32768, -32768, 32767, -32768);
    step(1'b1, 2, 0, -32768, 0);          // R4: exact multiple
    step(1'b1, 0, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit v;
      v = ($urandom % 4) != 0;
      if ($urandom % 4 == 0)
        step(v, longint'($urandom % 9) - 4, longint'($urandom % 9) - 4, tie16(), tie16());
      else
        step(v, rnd16(), rnd16(), rnd16(), rnd16());
    end

    repeat (6) step(1'b0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule